// File: doc/BRIEF.md
# Byte-Stream Register Access Bridge

This block sits between a byte-wide transport (a serial receiver, a packet FIFO or similar) and an on-chip register bus. It gathers incoming bytes into 32-bit words, least significant byte first. Each command starts with a header word. The top byte of the header selects the operation and the low 24 bits give the register address. The bridge then drives one write or read on the bus, or waits for a programmed time.

A write command takes one more word from the stream and writes it to the addressed register. A read command reads the addressed register and sends the 32-bit result back on the output byte stream, low byte first, honouring backpressure from the receiver. A delay command takes one more word, a microsecond count, and holds off the input for that long. Any other command code puts the bridge into a stopped state until the session reset input is pulsed. The session reset also discards a partly received word.

Top module: `wsb_bridge`

## Requirements
- R1: After reset, inReady is 1 and outValid, busWrEn and busRdEn are 0.
- R2: Header bytes are assembled least significant byte first; busAddr carries header bits [23:0] and the command code is header bits [31:24].
- R3: Command code 0x00 (write) consumes one more word; in the cycle after its fourth byte is accepted, busWrEn is 1 for exactly one cycle with busWrData equal to that word.
- R4: Command code 0x08 (read) raises busRdEn in the cycle after the header completes and holds it until busRdValid is seen; busWrEn and outValid stay 0 during that time.
- R5: The read result leaves on outData as four bytes, least significant byte first; while outValid is 1 and outReady is 0, outValid and outData hold.
- R6: Command code 0x01 (delay) consumes one more word N; inReady is then 0 for exactly N × (CLK_HZ / 1,000,000) + 1 cycles before it returns to 1.
- R7: Any other command code leaves inReady at 0 with no bus activity until sessRst is pulsed, after which commands are accepted again.
- R8: A sessRst pulse discards the bytes of a partly received word, so the next byte starts a new word.
- R9: inReady is 0 while a read is pending on the bus or its response bytes are being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sessRst | input | 1 | Synchronous session reset: clears the stopped state and partial word |
| inValid | input | 1 | Input byte present |
| inData | input | 8 | Input byte |
| inReady | output | 1 | Bridge accepts the input byte this cycle |
| outValid | output | 1 | Response byte present |
| outData | output | 8 | Response byte |
| outReady | input | 1 | Receiver takes the response byte this cycle |
| busWrEn | output | 1 | Register write strobe |
| busRdEn | output | 1 | Register read request, held until completion |
| busAddr | output | 24 | Register address |
| busWrData | output | 32 | Register write data |
| busRdData | input | 32 | Register read data |
| busRdValid | input | 1 | Read data valid, completes the read |

## Verification
A wrong byte count in the assembler shows on the very next command: the address or write data appears rotated by a whole byte on the bus, or the write strobe fires one byte early or late. A wrong control state shows within a cycle as inReady being high while a read response is pending, or as a bus strobe in the stopped state. A faulty delay counter is caught by counting the exact number of cycles inReady stays low, so an off-by-one in the microsecond prescaler is visible after the first delay command.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 24;
  localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
  localparam int CNT_W = $clog2(BYTES_PER_WORD);

  localparam logic [BYTE_W-1:0] CMD_POKE  = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_SLEEP = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_PEEK  = 8'h08;

  typedef struct packed {
    logic takeByte;
    logic sendByte;
    logic clrCnt;
    logic latchAddr;
    logic latchWr;
    logic latchRd;
    logic loadDelay;
    logic runDelay;
  } strobes_t;
endpackage

// File: rtl/wsb_datapath.sv
module wsb_datapath
  import wsb_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [BYTE_W-1:0] inData,
  input  logic [WORD_W-1:0] busRdData,
  output logic              lastByte,
  output logic [BYTE_W-1:0] cmdCode,
  output logic              delayDone,
  output logic [ADDR_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWrData,
  output logic [BYTE_W-1:0] outData
);
  localparam int TICK_DIV = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PRE_W = $clog2(TICK_DIV + 1);

  logic [WORD_W-1:0] asmWord;
  logic [WORD_W-1:0] asmNext;
  logic [CNT_W-1:0]  byteCnt;
  logic [WORD_W-1:0] respWord;
  logic [WORD_W-1:0] delayUs;
  logic [PRE_W-1:0]  preCnt;

  assign asmNext   = {inData, asmWord[WORD_W-1:BYTE_W]};
  assign cmdCode   = asmNext[WORD_W-1:WORD_W-BYTE_W];
  assign lastByte  = (byteCnt == CNT_W'(BYTES_PER_WORD - 1));
  assign delayDone = (delayUs == '0);
  assign outData   = respWord[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmWord <= '0;
      byteCnt <= '0;
    end else begin
      if (st.takeByte) asmWord <= asmNext;
      if (st.clrCnt) byteCnt <= '0;
      else if (st.takeByte || st.sendByte) byteCnt <= byteCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr   <= '0;
      busWrData <= '0;
      respWord  <= '0;
    end else begin
      if (st.latchAddr) busAddr <= asmNext[ADDR_W-1:0];
      if (st.latchWr) busWrData <= asmNext;
      if (st.latchRd) respWord <= busRdData;
      else if (st.sendByte) respWord <= {{BYTE_W{1'b0}}, respWord[WORD_W-1:BYTE_W]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayUs <= '0;
      preCnt  <= '0;
    end else if (st.loadDelay) begin
      delayUs <= asmNext;
      preCnt  <= '0;
    end else if (st.runDelay) begin
      if (preCnt == PRE_W'(TICK_DIV - 1)) begin
        preCnt  <= '0;
        delayUs <= delayUs - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wsb_control.sv
module wsb_control
  import wsb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sessRst,
  input  logic              inValid,
  input  logic              outReady,
  input  logic              busRdValid,
  input  logic              lastByte,
  input  logic [BYTE_W-1:0] cmdCode,
  input  logic              delayDone,
  output strobes_t          st,
  output logic              inReady,
  output logic              outValid,
  output logic              busWrEn,
  output logic              busRdEn
);
  typedef enum logic [2:0] {
    S_HDR, S_ARG, S_WR, S_RD, S_RESP, S_SLEEP, S_HALT
  } state_t;

  state_t state, stateNext;
  logic argSleep, argSleepNext;

  assign inReady  = (state == S_HDR) || (state == S_ARG);
  assign outValid = (state == S_RESP);
  assign busWrEn  = (state == S_WR);
  assign busRdEn  = (state == S_RD);

  always_comb begin
    st = '0;
    stateNext = state;
    argSleepNext = argSleep;
    if (sessRst) begin
      st.clrCnt = 1'b1;
      stateNext = S_HDR;
    end else begin
      unique case (state)
        S_HDR: if (inValid) begin
          st.takeByte = 1'b1;
          if (lastByte) begin
            st.clrCnt = 1'b1;
            st.latchAddr = 1'b1;
            if (cmdCode == CMD_POKE) begin
              stateNext = S_ARG;
              argSleepNext = 1'b0;
            end else if (cmdCode == CMD_SLEEP) begin
              stateNext = S_ARG;
              argSleepNext = 1'b1;
            end else if (cmdCode == CMD_PEEK) begin
              stateNext = S_RD;
            end else begin
              stateNext = S_HALT;
            end
          end
        end
        S_ARG: if (inValid) begin
          st.takeByte = 1'b1;
          if (lastByte) begin
            st.clrCnt = 1'b1;
            if (argSleep) begin
              st.loadDelay = 1'b1;
              stateNext = S_SLEEP;
            end else begin
              st.latchWr = 1'b1;
              stateNext = S_WR;
            end
          end
        end
        S_WR: stateNext = S_HDR;
        S_RD: if (busRdValid) begin
          st.latchRd = 1'b1;
          stateNext = S_RESP;
        end
        S_RESP: if (outReady) begin
          st.sendByte = 1'b1;
          if (lastByte) begin
            st.clrCnt = 1'b1;
            stateNext = S_HDR;
          end
        end
        S_SLEEP: begin
          if (delayDone) stateNext = S_HDR;
          else st.runDelay = 1'b1;
        end
        default: stateNext = S_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_HDR;
      argSleep <= 1'b0;
    end else begin
      state <= stateNext;
      argSleep <= argSleepNext;
    end
  end
endmodule

// File: rtl/wsb_bridge.sv
module wsb_bridge
  import wsb_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sessRst,
  input  logic        inValid,
  input  logic [7:0]  inData,
  output logic        inReady,
  output logic        outValid,
  output logic [7:0]  outData,
  input  logic        outReady,
  output logic        busWrEn,
  output logic        busRdEn,
  output logic [23:0] busAddr,
  output logic [31:0] busWrData,
  input  logic [31:0] busRdData,
  input  logic        busRdValid
);
  strobes_t          st;
  logic              lastByte;
  logic [BYTE_W-1:0] cmdCode;
  logic              delayDone;

  wsb_control i_control (
    .clk(clk), .rstN(rstN), .sessRst(sessRst), .inValid(inValid),
    .outReady(outReady), .busRdValid(busRdValid), .lastByte(lastByte),
    .cmdCode(cmdCode), .delayDone(delayDone), .st(st), .inReady(inReady),
    .outValid(outValid), .busWrEn(busWrEn), .busRdEn(busRdEn)
  );

  wsb_datapath #(.CLK_HZ(CLK_HZ)) i_datapath (
    .clk(clk), .rstN(rstN), .st(st), .inData(inData), .busRdData(busRdData),
    .lastByte(lastByte), .cmdCode(cmdCode), .delayDone(delayDone),
    .busAddr(busAddr), .busWrData(busWrData), .outData(outData)
  );
endmodule

// File: rtl/wsb_checker.sv
module wsb_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sessRst,
  input logic       inReady,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outReady,
  input logic       busWrEn,
  input logic       busRdEn,
  input logic       busRdValid
);
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |=> !busWrEn); // R3
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rstN || sessRst)
    busRdEn && !busRdValid |=> busRdEn); // R4
  AST_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |-> !busWrEn && !outValid); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN || sessRst)
    outValid && !outReady |=> outValid && $stable(outData)); // R5
  AST_NO_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (outValid || busRdEn) |-> !inReady); // R9
endmodule

bind wsb_bridge wsb_checker i_wsb_checker (
  .clk(clk), .rstN(rstN), .sessRst(sessRst), .inReady(inReady),
  .outValid(outValid), .outData(outData), .outReady(outReady),
  .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdValid(busRdValid)
);

// File: tb/test_wsb_bridge.sv
module test_wsb_bridge;
  localparam int CLK_HZ = 100_000_000;
  localparam int DIV = CLK_HZ / 1_000_000;
  localparam int NV = 6;
  // {op (0 write, 1 read), address, data or read value}
  localparam logic [57:0] VEC [NV] = '{
    {2'd0, 24'h000010, 32'h12345678},
    {2'd1, 24'h000010, 32'hCAFEF00D},
    {2'd0, 24'hABCDEF, 32'h00000001},
    {2'd1, 24'hFFFFFF, 32'h80000001},
    {2'd0, 24'h000000, 32'hFFFFFFFF},
    {2'd1, 24'h123456, 32'h00000000}
  };

  logic clk = 0, rstN = 0, sessRst = 0;
  logic inValid = 0, outReady = 0, busRdValid = 0;
  logic [7:0] inData = 0;
  logic [31:0] busRdData = 0;
  logic inReady, outValid, busWrEn, busRdEn;
  logic [7:0] outData;
  logic [23:0] busAddr;
  logic [31:0] busWrData;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wsb_bridge #(.CLK_HZ(CLK_HZ)) i_wsb_bridge (
    .clk(clk), .rstN(rstN), .sessRst(sessRst), .inValid(inValid),
    .inData(inData), .inReady(inReady), .outValid(outValid),
    .outData(outData), .outReady(outReady), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .busRdValid(busRdValid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inValid = 1; inData = b;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic sendWord(input logic [31:0] w);
    for (int k = 0; k < 4; k++) sendByte(w[8*k +: 8]);
  endtask

  task automatic doRead(input logic [31:0] d);
    for (int k = 0; k < 2; k++) begin
      chk("R4 outValid during read", {31'd0, outValid}, 32'd0);
      @(negedge clk);
    end
    chk("R4 busRdEn held", {31'd0, busRdEn}, 32'd1);
    busRdValid = 1; busRdData = d;
    @(negedge clk);
    busRdValid = 0;
  endtask

  task automatic recvWord(input int stall, output logic [31:0] w);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] first;
      while (!outValid) @(negedge clk);
      first = outData;
      if (stall > 0) begin
        repeat (stall) @(negedge clk);
        chk("R5 byte held under backpressure", {23'd0, outValid, outData}, {23'd0, 1'b1, first});
      end
      w[8*k +: 8] = outData;
      outReady = 1;
      @(negedge clk);
      outReady = 0;
    end
  endtask

  task automatic pulseSess();
    @(negedge clk); sessRst = 1;
    @(negedge clk); sessRst = 0;
  endtask

  task automatic doPoke(input string tag, input logic [23:0] a, input logic [31:0] d);
    sendWord({8'h00, a});
    sendWord(d);
    chk({tag, " busWrEn"}, {31'd0, busWrEn}, 32'd1);
    chk({tag, " busAddr"}, {8'd0, busAddr}, {8'd0, a});
    chk({tag, " busWrData"}, busWrData, d);
    @(negedge clk);
    chk({tag, " single strobe"}, {31'd0, busWrEn}, 32'd0);
  endtask

  task automatic runSleep(input logic [31:0] n);
    int cyc = 0;
    sendWord(32'h0100_0000);
    sendWord(n);
    while (!inReady) begin cyc++; @(negedge clk); end
    chk("R6 delay length", cyc, n * DIV + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic bad;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 inReady", {31'd0, inReady}, 32'd1);
    chk("R1 outValid/busWrEn/busRdEn", {29'd0, outValid, busWrEn, busRdEn}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [23:0] a;
      logic [31:0] d;
      {op, a, d} = VEC[i];
      if (op == 2'd0) begin
        doPoke("R3 R2 write vector", a, d);
      end else begin
        sendWord({8'h08, a});
        chk("R4 busRdEn raised", {31'd0, busRdEn}, 32'd1);
        chk("R2 read address", {8'd0, busAddr}, {8'd0, a});
        chk("R9 inReady low during read", {31'd0, inReady}, 32'd0);
        doRead(d);
        chk("R9 inReady low during response", {31'd0, inReady}, 32'd0);
        recvWord(i % 2 == 1 ? 3 : 0, w);
        chk("R5 read data LSB first", w, d);
      end
    end

    // R6 delay command, nonzero and zero
    runSleep(32'd3);
    runSleep(32'd0);
    doPoke("R6 write after delay", 24'h000777, 32'h0BADBEEF);

    // R7 unknown command code 0x42
    sendWord(32'h4200_0001);
    bad = 0;
    inValid = 1; inData = 8'h55;
    for (int c = 0; c < 20; c++) begin
      if (inReady || busWrEn || busRdEn || outValid) bad = 1;
      @(negedge clk);
    end
    inValid = 0;
    chk("R7 stopped after unknown code", {31'd0, bad}, 32'd0);
    pulseSess();
    chk("R7 inReady after session reset", {31'd0, inReady}, 32'd1);
    doPoke("R7 write after session reset", 24'h00ABCD, 32'h11223344);

    // R8 partial word discarded
    sendByte(8'hAA);
    sendByte(8'hBB);
    pulseSess();
    doPoke("R8 write after partial discard", 24'h000055, 32'h00000011);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule